// File: doc/BRIEF.md
# Fast-Lock Timeout Sequencer

This block times the acquisition phase of a frequency synthesizer loop after a new channel has been programmed. The register-interface logic raises `start` for one comparison-clock cycle whenever the main frequency word is written. The sequencer then drives three fast-lock controls. The first closes a pair of loop-filter switches. The second bypasses the post-amplifier filter so that the loop can slew quickly. The third enables the boosted charge-pump current. Each control is held until its own programmed timeout has elapsed.

The timeouts are measured in prescaled comparison cycles. A fixed divide-by-four prescaler produces one tick every four comparison-clock cycles. A single shared tick counter is compared against three independent 10-bit limits, and the limits are captured when the sequence starts. A limit of zero keeps that control off. A new start restarts the whole sequence from zero. `busy` shows that any control is still held.

Top module: `fl_timeout_seq`

## Requirements
- R1: In the cycle after `start` is sampled high, every enable whose limit was non-zero at that edge is high.
- R2: The tick counter advances once every 4 comparison-clock cycles. An enable with limit L (1 to 1023) stays high for exactly 4*L clock cycles and then goes low.
- R3: Each enable drops on the tick where the shared count reaches its own limit. The other enables are not affected.
- R4: A limit of zero keeps the corresponding enable low for the whole sequence.
- R5: A `start` during an active sequence reloads all limits and restarts the prescaler and the count from zero. This includes enables that had already dropped.
- R6: `busy` is high exactly when at least one of the three enables is high.
- R7: The limits are captured on the `start` edge. Changes on the limit inputs after that edge have no effect on the running sequence.
- R8: When `rst_n` is sampled low, all enables and `busy` are low in the next cycle. Reset takes priority over `start`.
- R9: The largest limit, 1023, gives a hold time of 4092 cycles, with no wrap of the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-comparison clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse on a write to the main frequency word |
| tmo_sw_pair | input | 10 | Timeout for the loop-filter switch pair, in prescaled ticks |
| tmo_bypass | input | 10 | Timeout for the filter-bypass switch, in prescaled ticks |
| tmo_cp_boost | input | 10 | Timeout for the boosted charge-pump current, in prescaled ticks |
| sw_pair_en | output | 1 | Loop-filter switch pair closed |
| bypass_en | output | 1 | Post-amplifier filter bypassed |
| cp_boost_en | output | 1 | Boosted charge-pump current enabled |
| busy | output | 1 | At least one fast-lock control is active |

## Verification
Each of the three internal state elements produces a distinct error at the enable pins.
- A wrong prescaler phase moves every release edge by up to three cycles, and this shows on the first release.
- A wrong tick count or a mis-captured limit changes the hold length of an enable by a multiple of four cycles. This is visible only when that enable is released, up to 4092 cycles after `start`.
- A stale enable across a restart shows as a control that stays off, or comes back too late, in the cycle after the second `start`.

The bench therefore measures every hold length exactly, cycle by cycle, and compares `busy` against the three enables on every cycle.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int unsigned NUM_CH    = 3;
  localparam int unsigned CH_PAIR   = 0;
  localparam int unsigned CH_BYPASS = 1;
  localparam int unsigned CH_CP     = 2;

  // Number of comparison-clock cycles an enable stays asserted.
  function automatic int unsigned hold_cycles(int unsigned limit, int unsigned prescale);
    return limit * prescale;
  endfunction

  // True when the count, after the increment that a tick applies, meets the limit.
  function automatic logic reaches_limit(int unsigned count, int unsigned limit);
    return (count + 1) == limit;
  endfunction
endpackage

// File: rtl/fl_prescaler.sv
module fl_prescaler #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart) begin
      phase <= '0;
    end else if (run) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end else begin
      phase <= '0;
    end
  end

  assign tick = run && !restart && (phase == LAST);
endmodule

// File: rtl/fl_tick_counter.sv
module fl_tick_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (restart) begin
      count <= '0;
    end else if (tick) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/fl_channel.sv
module fl_channel #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit_in,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit_q,
  output logic             expire,
  output logic             en
);
  import fl_pkg::*;

  assign expire = tick && en && reaches_limit(32'(count), 32'(limit_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      limit_q <= '0;
    end else if (restart) begin
      en      <= (limit_in != '0);
      limit_q <= limit_in;
    end else if (expire) begin
      en      <= 1'b0;
    end
  end
endmodule

// File: rtl/fl_timeout_seq.sv
module fl_timeout_seq #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] tmo_sw_pair,
  input  logic [CNT_W-1:0] tmo_bypass,
  input  logic [CNT_W-1:0] tmo_cp_boost,
  output logic             sw_pair_en,
  output logic             bypass_en,
  output logic             cp_boost_en,
  output logic             busy
);
  import fl_pkg::*;

  localparam int unsigned LIM_W = NUM_CH * CNT_W;

  logic [LIM_W-1:0]  lim_in_flat;
  logic [LIM_W-1:0]  lim_q_flat;
  logic [NUM_CH-1:0] en_vec;
  logic [NUM_CH-1:0] expire_vec;
  logic              tick;
  logic [CNT_W-1:0]  tick_cnt;

  assign lim_in_flat = {tmo_cp_boost, tmo_bypass, tmo_sw_pair};

  fl_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(start), .run(busy), .tick(tick)
  );

  fl_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(start), .tick(tick), .count(tick_cnt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    fl_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (start),
      .tick     (tick),
      .limit_in (lim_in_flat[i*CNT_W +: CNT_W]),
      .count    (tick_cnt),
      .limit_q  (lim_q_flat[i*CNT_W +: CNT_W]),
      .expire   (expire_vec[i]),
      .en       (en_vec[i])
    );
  end

  assign sw_pair_en  = en_vec[CH_PAIR];
  assign bypass_en   = en_vec[CH_BYPASS];
  assign cp_boost_en = en_vec[CH_CP];
  assign busy        = |en_vec;
endmodule

// File: rtl/fl_timeout_seq_chk.sv
module fl_timeout_seq_chk #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned NUM_CH = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    tick,
  input logic [CNT_W-1:0]        tick_cnt,
  input logic [NUM_CH*CNT_W-1:0] lim_in_flat,
  input logic [NUM_CH*CNT_W-1:0] lim_q_flat,
  input logic [NUM_CH-1:0]       en_vec
);
  // R8: reset clears every enable
  a_r8_reset_clears: assert property (@(posedge clk) !rst_n |=> !busy);

  // R2: ticks are never back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R6: an idle sequencer stays idle without a start
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !busy) |=> !busy);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R1: a non-zero limit raises its enable after start
    a_r1_start_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (start && lim_in_flat[i*CNT_W +: CNT_W] != '0) |=> en_vec[i]);

    // R4: a zero limit keeps its enable low
    a_r4_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
      (start && lim_in_flat[i*CNT_W +: CNT_W] == '0) |=> !en_vec[i]);

    // R3: a release without a start happens only on a tick at the channel limit
    a_r3_release_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(en_vec[i]) && !$past(start)) |->
        ($past(tick) && (({1'b0, $past(tick_cnt)} + 1'b1) ==
                         {1'b0, $past(lim_q_flat[i*CNT_W +: CNT_W])})));

    // R7: the captured limit stays fixed between starts
    a_r7_limit_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && $past(rst_n)) |=> $stable(lim_q_flat[i*CNT_W +: CNT_W]));
  end
endmodule

bind fl_timeout_seq fl_timeout_seq_chk #(.CNT_W(CNT_W), .NUM_CH(fl_pkg::NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .tick(tick),
  .tick_cnt(tick_cnt), .lim_in_flat(lim_in_flat), .lim_q_flat(lim_q_flat),
  .en_vec(en_vec)
);

// File: tb/fl_timeout_seq_tb.sv
module fl_timeout_seq_tb;
  localparam int unsigned CNT_W = 10;
  localparam int unsigned PS    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] t0 = '0, t1 = '0, t2 = '0;
  logic e0, e1, e2, busy;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fl_timeout_seq #(.CNT_W(CNT_W), .PRESCALE(PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .tmo_sw_pair(t0), .tmo_bypass(t1), .tmo_cp_boost(t2),
    .sw_pair_en(e0), .bypass_en(e1), .cp_boost_en(e2), .busy(busy)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse start with the given limits, then scramble the limit inputs (R7).
  task automatic pulse(input int a, input int b, input int c);
    @(negedge clk);
    t0 = CNT_W'(a); t1 = CNT_W'(b); t2 = CNT_W'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t0 = ~t0; t1 = ~t1; t2 = ~t2;
  endtask

  // Starts at the negedge right after the start edge; measures each hold length.
  task automatic measure(input int a, input int b, input int c, input string req);
    int lim[3];
    int hi[3];
    int mx;
    int busy_bad;
    lim[0] = a; lim[1] = b; lim[2] = c;
    hi = '{0, 0, 0};
    busy_bad = 0;
    mx = PS * ((a > b) ? ((a > c) ? a : c) : ((b > c) ? b : c));
    for (int k = 1; k <= mx + 3; k++) begin
      logic [2:0] ev;
      logic [2:0] xv;
      ev = {e2, e1, e0};
      for (int i = 0; i < 3; i++) begin
        xv[i] = (k <= PS * lim[i]);
        if (ev[i]) hi[i]++;
        if (ev[i] != xv[i]) busy_bad += 1000;
      end
      if (busy != (|ev)) busy_bad++;
      if (k <= mx + 2) @(negedge clk);
    end
    for (int i = 0; i < 3; i++)
      chk(hi[i] == PS * lim[i], {req, " R2 R3 R4 hold length"}, hi[i], PS * lim[i]);
    chk(busy_bad == 0, {req, " R6 busy and release timing"}, busy_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!e0 && !e1 && !e2 && !busy, "R8 reset state", {e2, e1, e0, busy}, 0);
    rst_n = 1'b1;

    // R1/R2/R4: sweep the pair channel over 0..12 against fixed others
    for (int l = 0; l <= 12; l++) begin
      pulse(l, 3, 0);
      chk({e1, e0} == {1'b1, (l != 0)}, "R1 enables after start", {e1, e0}, {1'b1, l != 0});
      measure(l, 3, 0, "sweep");
    end

    // R3: the three channels release independently in varied orders
    for (int p = 0; p < 6; p++) begin
      int a, b, c;
      a = (p % 3) + 1; b = ((p + 1) % 3) * 2 + 1; c = ((p + 2) % 3) * 3 + 2;
      pulse(a, b, c);
      measure(a, b, c, "R3 orders");
    end

    // R4: all zero means nothing asserts
    pulse(0, 0, 0);
    measure(0, 0, 0, "R4 all zero");

    // R5: a restart mid-sequence, after one channel has already dropped
    pulse(2, 5, 1);
    repeat (8) @(negedge clk);
    pulse(3, 0, 2);
    measure(3, 0, 2, "R5 restart");

    // R5: a restart on every prescaler phase
    for (int d = 0; d < 4; d++) begin
      pulse(4, 4, 4);
      repeat (d + 5) @(negedge clk);
      pulse(1, 2, 3);
      measure(1, 2, 3, "R5 phase restart");
    end

    // R9: maximum limits
    pulse(1023, 1, 512);
    measure(1023, 1, 512, "R9 max limit");

    // R8: reset overrides a simultaneous start in a running sequence
    pulse(5, 5, 5);
    repeat (3) @(negedge clk);
    rst_n = 1'b0; start = 1'b1; t0 = 10'd7; t1 = 10'd7; t2 = 10'd7;
    @(negedge clk);
    chk(!e0 && !e1 && !e2 && !busy, "R8 reset priority", {e2, e1, e0, busy}, 0);
    rst_n = 1'b1; start = 1'b0;
    @(negedge clk);
    chk(!busy, "R8 stays idle after reset", busy, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule